// File: doc/BRIEF.md
# Programmable Probe Trigger Unit

This block watches a bank of multi-bit probe signals and raises a single registered trigger pulse for a capture controller. Every probe owns one trigger slot holding an operation code and a constant as wide as the probe. An operation either compares the probe with its own value one clock earlier, or compares it with the slot's constant. The results of all slots are ORed with an optional external trigger input.

Slots are rewritten at run time through a small write port. Index values `0` to `NUM_PROBES-1` select a probe slot. Index `NUM_PROBES` selects the external-trigger enable. Each write restarts the history qualification, so the new condition never matches against a stale earlier sample.

Top module: `probe_trigger_unit`

## Requirements
- R1: Operation codes are 0=off, 1=rising, 2=falling, 3=changing, 4=greater-than, 5=less-than, 6=greater-or-equal, 7=less-or-equal, 8=equal, 9=not-equal. Codes 0 and 10..15 never contribute to the trigger.
- R2: Rising matches when the probe's unsigned value is strictly greater than its value on the previous clock.
- R3: Falling matches when the probe's unsigned value is strictly smaller than its value on the previous clock.
- R4: Changing matches when any bit of the probe differs from its value on the previous clock.
- R5: Codes 4..9 compare the probe, unsigned, against the slot's constant argument.
- R6: `trig_o` is registered. It reflects the probe and external-trigger values sampled at the preceding rising clock edge.
- R7: When several slots are armed, a match in any one of them asserts `trig_o`.
- R8: `ext_trig_i` asserts `trig_o` only while the external enable is set. The enable is bit 0 of `cfg_op_i`, written at index `NUM_PROBES`.
- R9: Edge operations (codes 1..3) are suppressed on the first sample after reset and on the first sample after any configuration write.
- R10: After reset `trig_o` is 0, every slot is off and the external enable is clear.
- R11: A write to a probe slot replaces both its operation and its argument. The new condition applies from the next sample on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| probes_i | input | NUM_PROBES*PROBE_W | Probe bus, probe k in bits [k*PROBE_W +: PROBE_W] |
| ext_trig_i | input | 1 | External trigger request |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W | Slot index, NUM_PROBES selects external enable |
| cfg_op_i | input | 4 | Operation code, or enable in bit 0 |
| cfg_arg_i | input | PROBE_W | Constant argument |
| trig_o | output | 1 | Registered trigger |

## Verification
A wrong history register shows up at the port as a spurious or missing edge trigger on the very next sample. For example, a stale previous value makes an unchanged probe look like it is rising. A history-valid flag that fails to clear makes the first sample after a write fire against the old value. A corrupted slot or enable register shows on `trig_o` one cycle after the first probe pattern that should or should not match. The directed scenarios place such patterns right after each write, so these faults appear within one or two clocks.

// File: rtl/ptu_pkg.sv
package ptu_pkg;
    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OP_OFF  = 4'd0;
    localparam logic [OP_W-1:0] OP_RISE = 4'd1;
    localparam logic [OP_W-1:0] OP_FALL = 4'd2;
    localparam logic [OP_W-1:0] OP_CHG  = 4'd3;
    localparam logic [OP_W-1:0] OP_GT   = 4'd4;
    localparam logic [OP_W-1:0] OP_LT   = 4'd5;
    localparam logic [OP_W-1:0] OP_GEQ  = 4'd6;
    localparam logic [OP_W-1:0] OP_LEQ  = 4'd7;
    localparam logic [OP_W-1:0] OP_EQ   = 4'd8;
    localparam logic [OP_W-1:0] OP_NEQ  = 4'd9;

    function automatic logic is_edge_op(input logic [OP_W-1:0] op);
        return (op == OP_RISE) || (op == OP_FALL) || (op == OP_CHG);
    endfunction
endpackage

// File: rtl/ptu_slot.sv
module ptu_slot
    import ptu_pkg::*;
#(
    parameter int PROBE_W = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_i,
    input  logic [OP_W-1:0]    op_i,
    input  logic [PROBE_W-1:0] arg_i,
    input  logic [PROBE_W-1:0] cur_i,
    input  logic [PROBE_W-1:0] prev_i,
    input  logic               hist_vld_i,
    output logic               hit_o
);
    typedef struct packed {
        logic [OP_W-1:0]    op;
        logic [PROBE_W-1:0] arg;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_i) begin
            s_d.op  = op_i;
            s_d.arg = arg_i;
        end
        hit_o = 1'b0;
        case (s_q.op)
            OP_RISE: hit_o = hist_vld_i && (cur_i > prev_i);
            OP_FALL: hit_o = hist_vld_i && (cur_i < prev_i);
            OP_CHG:  hit_o = hist_vld_i && (cur_i != prev_i);
            OP_GT:   hit_o = cur_i >  s_q.arg;
            OP_LT:   hit_o = cur_i <  s_q.arg;
            OP_GEQ:  hit_o = cur_i >= s_q.arg;
            OP_LEQ:  hit_o = cur_i <= s_q.arg;
            OP_EQ:   hit_o = cur_i == s_q.arg;
            OP_NEQ:  hit_o = cur_i != s_q.arg;
            default: hit_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    // R1
    off_slot_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.op == OP_OFF || s_q.op > OP_NEQ) |-> !hit_o);

    // R9
    edge_needs_history_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (is_edge_op(s_q.op) && hit_o) |-> hist_vld_i);

    // R2
    rise_is_increase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.op == OP_RISE && hit_o) |-> (cur_i > prev_i));

    // R3
    fall_is_decrease_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.op == OP_FALL && hit_o) |-> (cur_i < prev_i));
endmodule

// File: rtl/probe_trigger_unit.sv
module probe_trigger_unit
    import ptu_pkg::*;
#(
    parameter int NUM_PROBES = 4,
    parameter int PROBE_W    = 8,
    localparam int BUS_W     = NUM_PROBES * PROBE_W,
    localparam int IDX_W     = $clog2(NUM_PROBES + 1)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [BUS_W-1:0]   probes_i,
    input  logic               ext_trig_i,
    input  logic               cfg_we_i,
    input  logic [IDX_W-1:0]   cfg_idx_i,
    input  logic [OP_W-1:0]    cfg_op_i,
    input  logic [PROBE_W-1:0] cfg_arg_i,
    output logic               trig_o
);
    localparam logic [IDX_W-1:0] EXT_IDX = IDX_W'(NUM_PROBES);

    typedef struct packed {
        logic [BUS_W-1:0] prev;
        logic             hist_vld;
        logic             ext_en;
        logic             trig;
    } core_t;

    core_t c_d, c_q;
    logic [NUM_PROBES-1:0] slot_hit;
    logic                  ext_hit;

    for (genvar k = 0; k < NUM_PROBES; k++) begin : g_slot
        ptu_slot #(.PROBE_W(PROBE_W)) u_slot (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .wr_i       (cfg_we_i && (cfg_idx_i == IDX_W'(k))),
            .op_i       (cfg_op_i),
            .arg_i      (cfg_arg_i),
            .cur_i      (probes_i[k*PROBE_W +: PROBE_W]),
            .prev_i     (c_q.prev[k*PROBE_W +: PROBE_W]),
            .hist_vld_i (c_q.hist_vld),
            .hit_o      (slot_hit[k])
        );
    end

    assign ext_hit = c_q.ext_en && ext_trig_i;

    always_comb begin
        c_d          = c_q;
        c_d.prev     = probes_i;
        c_d.hist_vld = !cfg_we_i;
        if (cfg_we_i && cfg_idx_i == EXT_IDX) c_d.ext_en = cfg_op_i[0];
        c_d.trig     = (|slot_hit) || ext_hit;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) c_q <= '0;
        else         c_q <= c_d;
    end

    assign trig_o = c_q.trig;

    // R6
    quiet_gives_no_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ext_hit && slot_hit == '0) |=> !trig_o);

    // R7
    any_slot_trigs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|slot_hit) |=> trig_o);

    // R9
    write_clears_history_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_we_i |=> !c_q.hist_vld);

    // R8
    ext_disabled_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!c_q.ext_en && slot_hit == '0) |=> !trig_o);
endmodule

// File: tb/probe_trigger_unit_tb.sv
module probe_trigger_unit_tb;
    localparam int N = 4;
    localparam int W = 8;
    localparam int IW = $clog2(N + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0][W-1:0] pv = '0;
    logic ext = 1'b0;
    logic we = 1'b0;
    logic [IW-1:0] idx = '0;
    logic [3:0] op = '0;
    logic [W-1:0] arg = '0;
    logic trig;
    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    probe_trigger_unit #(.NUM_PROBES(N), .PROBE_W(W)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .probes_i(pv), .ext_trig_i(ext),
        .cfg_we_i(we), .cfg_idx_i(idx), .cfg_op_i(op), .cfg_arg_i(arg),
        .trig_o(trig)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic exp);
        checks++;
        if (trig !== exp) begin
            errors++;
            $display("FAIL %s: trig_o=%b expected %b", req, trig, exp);
        end
    endtask

    task automatic cfg(input int i, input logic [3:0] o, input logic [W-1:0] a);
        we = 1'b1; idx = IW'(i); op = o; arg = a;
        step();
        we = 1'b0;
    endtask

    task automatic sample(input int p, input logic [W-1:0] v, input string req, input logic exp);
        pv[p] = v;
        step();
        check(req, exp);
    endtask

    task automatic t_reset();
        step();
        check("R10", 1'b0);
        sample(0, 8'h33, "R10", 1'b0);
        ext = 1'b1;
        sample(1, 8'h44, "R10", 1'b0);
        ext = 1'b0;
    endtask

    task automatic t_rising();
        pv[0] = 8'd0;
        cfg(0, 4'd1, '0);
        sample(0, 8'd5, "R9", 1'b0);
        sample(0, 8'd7, "R2", 1'b1);
        sample(0, 8'd3, "R2", 1'b0);
        sample(0, 8'd3, "R2", 1'b0);
    endtask

    task automatic t_falling();
        cfg(0, 4'd2, '0);
        sample(0, 8'd3, "R9", 1'b0);
        sample(0, 8'd2, "R3", 1'b1);
        sample(0, 8'd9, "R3", 1'b0);
    endtask

    task automatic t_changing();
        cfg(0, 4'd3, '0);
        sample(0, 8'd8, "R9", 1'b0);
        sample(0, 8'd8, "R4", 1'b0);
        sample(0, 8'd9, "R4", 1'b1);
    endtask

    task automatic t_const();
        cfg(0, 4'd7, 8'd4);
        sample(0, 8'd4, "R5", 1'b1);
        sample(0, 8'd5, "R5", 1'b0);
        cfg(0, 4'd4, 8'd200);
        sample(0, 8'd201, "R11", 1'b1);
        sample(0, 8'd200, "R5", 1'b0);
        sample(0, 8'd255, "R5", 1'b1);
        cfg(0, 4'd5, 8'd10);
        sample(0, 8'd9, "R5", 1'b1);
        sample(0, 8'd10, "R5", 1'b0);
        cfg(0, 4'd6, 8'd10);
        sample(0, 8'd10, "R5", 1'b1);
        sample(0, 8'd9, "R5", 1'b0);
        cfg(0, 4'd8, 8'h5A);
        sample(0, 8'h5A, "R5", 1'b1);
        sample(0, 8'h5B, "R5", 1'b0);
        cfg(0, 4'd9, 8'h5A);
        sample(0, 8'h5B, "R5", 1'b1);
        sample(0, 8'h5A, "R5", 1'b0);
    endtask

    task automatic t_disabled();
        cfg(0, 4'd0, 8'h00);
        sample(0, 8'h00, "R1", 1'b0);
        sample(0, 8'hFF, "R1", 1'b0);
        cfg(0, 4'd12, 8'h00);
        sample(0, 8'h00, "R1", 1'b0);
        sample(0, 8'hFF, "R1", 1'b0);
        cfg(0, 4'd0, 8'h00);
    endtask

    task automatic t_or();
        cfg(1, 4'd8, 8'h11);
        cfg(2, 4'd8, 8'h22);
        sample(1, 8'h11, "R7", 1'b1);
        pv[1] = 8'h00;
        sample(2, 8'h22, "R7", 1'b1);
        sample(2, 8'h00, "R7", 1'b0);
        cfg(1, 4'd0, '0);
        cfg(2, 4'd0, '0);
    endtask

    task automatic t_ext();
        ext = 1'b1;
        step();
        check("R8", 1'b0);
        cfg(N, 4'd1, '0);
        step();
        check("R8", 1'b1);
        ext = 1'b0;
        step();
        check("R8", 1'b0);
        cfg(N, 4'd0, '0);
        ext = 1'b1;
        step();
        check("R8", 1'b0);
        ext = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_rising();
        t_falling();
        t_changing();
        t_const();
        t_disabled();
        t_or();
        t_ext();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule